// File: doc/BRIEF.md
# Interleaved Host Address Window Decoder

This block maps a host physical address onto a device-local address for one memory window. Software programs the window start and length as 64-bit quantities, each written as two 32-bit words. It also sets a granularity field and an interleave selector-width field in a control word, and then asks for a commit. Once the commit has taken effect, the window is locked and live.

Each lookup carries a 64-bit host address. The block checks that the address lies inside the window and removes the interleave selector bits from the middle of the offset. It then checks the result against the size of the backing memory. One cycle later it answers with either a hit and a device address, or a miss.

Top module: `hpa_window_decoder`

## Requirements
- R1: After reset every register reads 0, the committed flag is clear, and both `rsp_hit` and `rsp_miss` are low.
- R2: Register words sit at byte offsets 0x00 (start, bits 31:0), 0x04 (start, bits 63:32), 0x08 (length, bits 31:0), 0x0C (length, bits 63:32) and 0x10 (control). The control word holds granularity in bits 3:0, selector width in bits 7:4, commit request in bit 8, error in bit 9 and committed in bit 10; the committed bit is read-only. A write is ignored if its offset is not a multiple of 4 or if it falls outside these five words, and such offsets read as 0.
- R3: A write to the control word with bit 8 set is stored on that edge. On the next clock edge the commit request and error bits read 0 and the committed bit reads 1.
- R4: Every lookup misses while the committed bit is clear.
- R5: A lookup misses when the host address is below the start, or when the offset (host address minus start) is greater than or equal to the length.
- R6: The device address equals the low (8+G) offset bits unchanged, ORed with the offset bits from position (8+G+W) upward shifted right by W. G is the granularity and W is the selector width. The W bits between these two ranges are dropped.
- R7: A lookup misses when the device address is greater than the parameter `MEM_BYTES`. A device address exactly equal to `MEM_BYTES` still hits.
- R8: While committed, writes to any register are ignored. The committed bit stays set until reset.
- R9: A request with `req_valid` high yields exactly one of `rsp_hit`/`rsp_miss` on the next clock edge. Both are low after a cycle with no request, and `rsp_dev_addr` is 0 unless `rsp_hit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` (combinational) |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 64 | Host physical address to translate |
| rsp_hit | output | 1 | Registered: lookup translated |
| rsp_miss | output | 1 | Registered: lookup rejected |
| rsp_dev_addr | output | 64 | Registered device address, 0 on miss |

## Verification
The translation is swept over a grid of granularity and selector-width settings, with a fresh reset and commit for each setting. For each setting, a stride of offsets that are not powers of two runs across the window and past its end. These offsets set bits inside, below and above the dropped selector field, so a wrong boundary or a wrong shift amount shows up as a wrong device address. Fixed probes at start minus one, start, length minus one, length, and at the memory-size limit and one past it separate an off-by-one in each of the three compares. Lookups before the commit, writes to unaligned and unmapped offsets, and writes after the commit show whether the lock and the commit timing gate the window and the registers.

// File: rtl/hdm_win_pkg.sv
`timescale 1ns/1ps
package hdm_win_pkg;
  localparam int ADDR_W    = 64;
  localparam int WORD_W    = 32;
  localparam int GRAN_W    = 4;
  localparam int WAYS_W    = 4;
  localparam int GRAN_BASE = 8;

  // word indexes of the register block
  localparam int W_START_LO = 0;
  localparam int W_START_HI = 1;
  localparam int W_LEN_LO   = 2;
  localparam int W_LEN_HI   = 3;
  localparam int W_CTRL     = 4;

  // control word field positions
  localparam int C_GRAN_LSB = 0;
  localparam int C_WAYS_LSB = 4;
  localparam int C_COMMIT   = 8;
  localparam int C_ERR      = 9;
  localparam int C_DONE     = 10;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] len;
    logic [GRAN_W-1:0] gran;
    logic [WAYS_W-1:0] ways;
  } win_cfg_t;

  // keep the low (GRAN_BASE+gran) bits, close the gap left by the selector bits
  function automatic logic [ADDR_W-1:0] strip_ways(input logic [ADDR_W-1:0] off,
                                                   input logic [GRAN_W-1:0] gran,
                                                   input logic [WAYS_W-1:0] ways);
    int unsigned keep;
    logic [ADDR_W-1:0] low_mask;
    keep     = GRAN_BASE + int'(gran);
    low_mask = (ADDR_W'(1) << keep) - ADDR_W'(1);
    return (off & low_mask) | ((off >> (keep + int'(ways))) << keep);
  endfunction
endpackage

// File: rtl/hdm_win_regs.sv
`timescale 1ns/1ps
module hdm_win_regs
  import hdm_win_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output win_cfg_t          cfg_o,
  output logic              committed_o
);
  localparam int IDX_W = REG_AW - 2;

  logic [WORD_W-1:0] start_lo, start_hi, len_lo, len_hi;
  logic [GRAN_W-1:0] gran;
  logic [WAYS_W-1:0] ways;
  logic              commit_req, err_flag, committed;

  wire [IDX_W-1:0] word_idx = addr[REG_AW-1:2];
  wire             aligned  = (addr[1:0] == 2'b00);
  wire             wr_ok    = wr_en && aligned && !committed;
  wire             commit_fire = commit_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_lo   <= '0;
      start_hi   <= '0;
      len_lo     <= '0;
      len_hi     <= '0;
      gran       <= '0;
      ways       <= '0;
      commit_req <= 1'b0;
      err_flag   <= 1'b0;
      committed  <= 1'b0;
    end else if (commit_fire) begin
      commit_req <= 1'b0;
      err_flag   <= 1'b0;
      committed  <= 1'b1;
    end else if (wr_ok) begin
      case (int'(word_idx))
        W_START_LO: start_lo <= wdata;
        W_START_HI: start_hi <= wdata;
        W_LEN_LO:   len_lo   <= wdata;
        W_LEN_HI:   len_hi   <= wdata;
        W_CTRL: begin
          gran       <= wdata[C_GRAN_LSB +: GRAN_W];
          ways       <= wdata[C_WAYS_LSB +: WAYS_W];
          commit_req <= wdata[C_COMMIT];
          err_flag   <= wdata[C_ERR];
        end
        default: ;
      endcase
    end
  end

  logic [WORD_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[C_GRAN_LSB +: GRAN_W] = gran;
    ctrl_word[C_WAYS_LSB +: WAYS_W] = ways;
    ctrl_word[C_COMMIT] = commit_req;
    ctrl_word[C_ERR]    = err_flag;
    ctrl_word[C_DONE]   = committed;
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (int'(word_idx))
        W_START_LO: rdata = start_lo;
        W_START_HI: rdata = start_hi;
        W_LEN_LO:   rdata = len_lo;
        W_LEN_HI:   rdata = len_hi;
        W_CTRL:     rdata = ctrl_word;
        default:    rdata = '0;
      endcase
    end
  end

  assign cfg_o       = '{start: {start_hi, start_lo}, len: {len_hi, len_lo}, gran: gran, ways: ways};
  assign committed_o = committed;

  // R3: commit completes on the clock after the request is stored
  a_r3_commit_next: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (committed && !commit_req && !err_flag));
  // R8: committed stays set
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    committed |=> committed);
  // R8: configuration frozen while committed
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    committed |=> $stable(cfg_o));
endmodule

// File: rtl/hdm_win_lookup.sv
`timescale 1ns/1ps
module hdm_win_lookup
  import hdm_win_pkg::*;
#(
  parameter logic [63:0] MEM_BYTES = 64'h0000_0000_0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  win_cfg_t          cfg,
  input  logic              committed,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [ADDR_W-1:0] rsp_dev_addr
);
  wire [ADDR_W-1:0] offset     = req_addr - cfg.start;
  wire              below      = req_addr < cfg.start;
  wire              past_end   = offset >= cfg.len;
  wire [ADDR_W-1:0] dev_addr   = strip_ways(offset, cfg.gran, cfg.ways);
  wire              beyond_mem = dev_addr > MEM_BYTES;
  wire              lookup_hit = req_valid && committed && !below && !past_end && !beyond_mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_dev_addr <= '0;
    end else begin
      rsp_hit      <= lookup_hit;
      rsp_miss     <= req_valid && !lookup_hit;
      rsp_dev_addr <= lookup_hit ? dev_addr : '0;
    end
  end

  // R9: never both flags
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss}));
  // R9: one answer per request, one cycle later
  a_r9_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit || rsp_miss));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_hit && !rsp_miss));
  a_r9_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_dev_addr == '0));
  // R4: uncommitted window never hits
  a_r4_uncommitted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !committed) |=> rsp_miss);
  // R5: address below the start misses
  a_r5_below: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr < cfg.start)) |=> rsp_miss);
  // R7: a hit never reports beyond backing memory
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_dev_addr <= MEM_BYTES));
endmodule

// File: rtl/hpa_window_decoder.sv
`timescale 1ns/1ps
module hpa_window_decoder
  import hdm_win_pkg::*;
#(
  parameter int          REG_AW    = 5,
  parameter logic [63:0] MEM_BYTES = 64'h0000_0000_0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [63:0]       rsp_dev_addr
);
  win_cfg_t win_cfg;
  logic     win_committed;

  hdm_win_regs #(.REG_AW(REG_AW)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .cfg_o       (win_cfg),
    .committed_o (win_committed)
  );

  hdm_win_lookup #(.MEM_BYTES(MEM_BYTES)) i_lookup (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg          (win_cfg),
    .committed    (win_committed),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_dev_addr (rsp_dev_addr)
  );
endmodule

// File: tb/test_hpa_window_decoder.sv
`timescale 1ns/1ps
module test_hpa_window_decoder;
  localparam logic [63:0] MEM   = 64'h0000_0000_0010_0000;
  localparam logic [63:0] START = 64'h0000_0003_8000_0000;
  localparam logic [63:0] LEN   = 64'h0000_0000_0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_hit, rsp_miss;
  logic [63:0] rsp_dev_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hpa_window_decoder #(.REG_AW(5), .MEM_BYTES(MEM)) i_hpa_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_dev_addr(rsp_dev_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic lookup(input logic [63:0] a, output logic h, output logic m, output logic [63:0] dv);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    h = rsp_hit; m = rsp_miss; dv = rsp_dev_addr;
  endtask

  // independent bitwise model of the selector-bit removal
  function automatic logic [63:0] ref_dev(input logic [63:0] off, input int g, input int w);
    logic [63:0] r;
    r = '0;
    for (int b = 0; b < 64; b++) begin
      int src;
      src = (b < 8 + g) ? b : b + w;
      if (src < 64) r[b] = off[src];
    end
    return r;
  endfunction

  function automatic logic [31:0] ctrl_val(input int g, input int w, input bit commit, input bit err);
    return 32'(g) | (32'(w) << 4) | (32'(commit) << 8) | (32'(err) << 9);
  endfunction

  task automatic program_win(input int g, input int w);
    wr(5'h00, START[31:0]);
    wr(5'h04, START[63:32]);
    wr(5'h08, LEN[31:0]);
    wr(5'h0C, LEN[63:32]);
    wr(5'h10, ctrl_val(g, w, 1'b0, 1'b0));
  endtask

  task automatic probe(input string tag, input logic [63:0] a, input int g, input int w);
    logic h, m;
    logic [63:0] dv, off, d;
    logic eh;
    off = a - START;
    d   = ref_dev(off, g, w);
    eh  = (a >= START) && (off < LEN) && (d <= MEM);
    lookup(a, h, m, dv);
    chk({tag, " hit"}, 64'(h), 64'(eh));
    chk({tag, " miss"}, 64'(m), 64'(!eh));
    chk({tag, " dev"}, dv, eh ? d : 64'h0);
  endtask

  initial begin
    logic [31:0] d;
    logic h, m;
    logic [63:0] dv;

    do_reset();
    // R1: reset state
    for (int i = 0; i < 5; i++) begin
      rd(5'(i * 4), d);
      chk("R1 reg after reset", 64'(d), 64'h0);
    end
    @(negedge clk);
    chk("R1 hit idle", 64'(rsp_hit), 64'h0);
    chk("R1 miss idle", 64'(rsp_miss), 64'h0);

    // R2: programming and read back
    program_win(1, 2);
    rd(5'h00, d); chk("R2 start lo", 64'(d), 64'(START[31:0]));
    rd(5'h04, d); chk("R2 start hi", 64'(d), 64'(START[63:32]));
    rd(5'h08, d); chk("R2 len lo", 64'(d), 64'(LEN[31:0]));
    rd(5'h0C, d); chk("R2 len hi", 64'(d), 64'(LEN[63:32]));
    rd(5'h10, d); chk("R2 ctrl", 64'(d), 64'(ctrl_val(1, 2, 1'b0, 1'b0)));
    wr(5'h01, 32'hDEAD_BEEF);
    rd(5'h00, d); chk("R2 unaligned write ignored", 64'(d), 64'(START[31:0]));
    wr(5'h14, 32'h1234_5678);
    rd(5'h14, d); chk("R2 unmapped reads zero", 64'(d), 64'h0);
    for (int i = 0; i < 5; i++) begin
      rd(5'(i * 4), d);
      chk("R2 unmapped write no effect", 64'(d),
          i == 4 ? 64'(ctrl_val(1, 2, 1'b0, 1'b0)) :
          i == 0 ? 64'(START[31:0]) : i == 1 ? 64'(START[63:32]) :
          i == 2 ? 64'(LEN[31:0]) : 64'(LEN[63:32]));
    end

    // R4: window is programmed but not committed
    lookup(START + 64'h100, h, m, dv);
    chk("R4 uncommitted hit", 64'(h), 64'h0);
    chk("R4 uncommitted miss", 64'(m), 64'h1);
    chk("R4 uncommitted dev", dv, 64'h0);

    // R3: commit timing (error bit set in the same write, must clear)
    wr(5'h10, ctrl_val(1, 2, 1'b1, 1'b1));
    rd(5'h10, d);
    chk("R3 ctrl right after write", 64'(d), 64'(ctrl_val(1, 2, 1'b1, 1'b1)));
    @(negedge clk);
    rd(5'h10, d);
    chk("R3 ctrl one clock later", 64'(d), 64'(ctrl_val(1, 2, 1'b0, 1'b0) | 32'h400));

    // R9: idle cycle after a lookup
    lookup(START, h, m, dv);
    chk("R9 one answer", 64'(h ^ m), 64'h1);
    @(negedge clk);
    chk("R9 idle hit", 64'(rsp_hit), 64'h0);
    chk("R9 idle miss", 64'(rsp_miss), 64'h0);

    // R5 R6 R7: sweep of granularity and selector widths
    for (int g = 0; g < 3; g++) begin
      for (int w = 0; w < 3; w++) begin
        do_reset();
        program_win(g, w);
        wr(5'h10, ctrl_val(g, w, 1'b1, 1'b0));
        @(negedge clk);
        for (int i = 0; i < 80; i++)
          probe("R6 sweep", START + 64'(i) * 64'h0000_D3A1, g, w);
        probe("R5 below start", START - 64'h1, g, w);
        probe("R5 at start", START, g, w);
        probe("R5 last byte", START + LEN - 64'h1, g, w);
        probe("R5 at end", START + LEN, g, w);
        probe("R7 at mem limit", START + MEM, g, w);
        probe("R7 past mem limit", START + MEM + 64'h1, g, w);
      end
    end

    // R7: explicit boundary with identity translation
    do_reset();
    program_win(0, 0);
    wr(5'h10, ctrl_val(0, 0, 1'b1, 1'b0));
    @(negedge clk);
    lookup(START + MEM, h, m, dv);
    chk("R7 equal to mem size hits", 64'(h), 64'h1);
    chk("R7 equal dev", dv, MEM);
    lookup(START + MEM + 64'h1, h, m, dv);
    chk("R7 above mem size misses", 64'(m), 64'h1);

    // R8: writes after commit ignored
    wr(5'h00, 32'h0000_0000);
    wr(5'h08, 32'h0000_0010);
    wr(5'h10, ctrl_val(3, 1, 1'b0, 1'b1));
    rd(5'h00, d); chk("R8 start locked", 64'(d), 64'(START[31:0]));
    rd(5'h08, d); chk("R8 len locked", 64'(d), 64'(LEN[31:0]));
    rd(5'h10, d); chk("R8 ctrl locked", 64'(d), 64'(ctrl_val(0, 0, 1'b0, 1'b0) | 32'h400));
    lookup(START + 64'h2345, h, m, dv);
    chk("R8 translation unchanged", dv, 64'h2345);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule